// File: doc/BRIEF.md
# Direction-Aware Byte Queue with Threshold Flag

This block is the byte queue that sits between a host-side data path and a serial memory engine during indirect transfers. It holds up to 64 bytes in first-in, first-out order. A producer writes bytes on one side and a consumer reads them on the other. A single control bit tells the block which way the transfer runs. The threshold flag then counts whichever kind of byte matters to the host: empty slots when the host writes to the device, stored bytes when the host reads from it.

The host programs a 6-bit threshold field. A field value of N raises the flag once at least N+1 bytes qualify, so the field spans the range from one byte to all 64. The flag is a level, not an event, and it follows the current fill count, the threshold and the direction without delay. Two gated copies of the flag leave the block. One is an interrupt line, gated by its enable bit. The other is a DMA request line, gated by the DMA enable bit. An abort input empties the queue at once.

Top module: `ift_top`

## Requirements
- R1: After reset the fill level is 0, `empty_o` is 1 and `full_o` is 0. With `dir_rd_i`=1 the flag is 0. With `dir_rd_i`=0 the flag is 1 for any threshold value.
- R2: A push while not full stores `push_data_i` and raises the level by one. A pop while not empty removes the oldest byte and lowers the level by one. `pop_data_o` always shows the oldest stored byte, so bytes leave in the order they arrived.
- R3: A push while the level is 64 is ignored. The level stays 64 and the stored bytes are unchanged.
- R4: A pop while the level is 0 is ignored and the level stays 0.
- R5: A push and a pop in the same cycle are judged on the level at the start of the cycle. With the level strictly between 0 and 64, both are accepted and the level does not change. At level 0 only the push is taken. At level 64 only the pop is taken.
- R6: With `dir_rd_i`=1 (read direction), `thr_flag_o` is 1 exactly when the level is at least `thr_i`+1.
- R7: With `dir_rd_i`=0 (write direction), `thr_flag_o` is 1 exactly when 64 minus the level is at least `thr_i`+1.
- R8: The flag is combinational on the stored level. A change of `thr_i` or `dir_rd_i` shows on `thr_flag_o` without waiting for a clock edge.
- R9: `irq_o` equals `thr_flag_o` AND `irq_en_i`.
- R10: `dma_req_o` equals `thr_flag_o` AND `dma_en_i`.
- R11: `flush_i` high at a clock edge leaves the queue empty after that edge. A push or pop in the same cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Abort: empty the queue at the next edge |
| dir_rd_i | input | 1 | 0 = write direction (count free slots), 1 = read direction (count stored bytes) |
| thr_i | input | 6 | Threshold field; N means N+1 bytes |
| irq_en_i | input | 1 | Threshold interrupt enable |
| dma_en_i | input | 1 | DMA enable |
| push_i | input | 1 | Push strobe |
| push_data_i | input | 8 | Byte to push |
| pop_i | input | 1 | Pop strobe |
| pop_data_o | output | 8 | Oldest stored byte |
| level_o | output | 7 | Number of stored bytes, 0 to 64 |
| empty_o | output | 1 | Level is 0 |
| full_o | output | 1 | Level is 64 |
| thr_flag_o | output | 1 | Threshold flag |
| irq_o | output | 1 | Gated threshold interrupt |
| dma_req_o | output | 1 | Gated DMA request |

## Verification
The bench sweeps the level through its whole range in both directions at thresholds 0, mid-range and 63. This catches an off-by-one in the N+1 rule, which would move the flag edge by one byte, and a swapped direction, which would invert the flag across the sweep. It pushes into a full queue and pops from an empty one, then drains the queue. A design that let the count wrap would report a level of 0 or 63, and one that overwrote storage would return a foreign byte. Simultaneous push and pop at both extremes and abort combined with a push expose designs that judge acceptance on the updated level or let a strobe leak past the flush.

// File: rtl/ift_pkg.sv
package ift_pkg;

    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } ift_dir_e;

endpackage

// File: rtl/ift_mem.sv
module ift_mem #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk_i,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);

    logic [DW-1:0] cell_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) begin
            cell_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = cell_q[raddr_i];

endmodule

// File: rtl/ift_thresh.sv
module ift_thresh
    import ift_pkg::*;
#(
    parameter int DEPTH  = 64,
    localparam int THR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [LVL_W-1:0] level_i,
    input  logic [THR_W-1:0] thr_i,
    input  logic             dir_rd_i,
    output logic             flag_o
);

    localparam logic [LVL_W-1:0] CAP = LVL_W'(DEPTH);

    ift_dir_e         dir;
    logic [LVL_W-1:0] qual;
    logic [LVL_W-1:0] need;

    always_comb begin
        dir  = ift_dir_e'(dir_rd_i);
        qual = (dir == DIR_READ) ? level_i : (CAP - level_i);
        need = LVL_W'(thr_i) + LVL_W'(1);
        flag_o = (qual >= need);
    end

    // R7: an empty queue offers every slot, so any threshold is met
    assert_wr_empty_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!dir_rd_i && level_i == '0) |-> flag_o);

    // R6: nothing stored means no read threshold can be met
    assert_rd_empty_noflag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dir_rd_i && level_i == '0) |-> !flag_o);

    // R6: a full queue meets every read threshold
    assert_rd_full_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dir_rd_i && level_i == CAP) |-> flag_o);

endmodule

// File: rtl/ift_top.sv
module ift_top
    import ift_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int DW     = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int THR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             flush_i,
    input  logic             dir_rd_i,
    input  logic [THR_W-1:0] thr_i,
    input  logic             irq_en_i,
    input  logic             dma_en_i,
    input  logic             push_i,
    input  logic [DW-1:0]    push_data_i,
    input  logic             pop_i,
    output logic [DW-1:0]    pop_data_o,
    output logic [LVL_W-1:0] level_o,
    output logic             empty_o,
    output logic             full_o,
    output logic             thr_flag_o,
    output logic             irq_o,
    output logic             dma_req_o
);

    localparam logic [LVL_W-1:0] CAP     = LVL_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [LVL_W-1:0] lvl;
    } ift_state_t;

    ift_state_t st_d, st_q;
    logic       push_ok, pop_ok, wr_en;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_TOP) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        st_d    = st_q;
        push_ok = push_i && (st_q.lvl != CAP);
        pop_ok  = pop_i && (st_q.lvl != '0);
        wr_en   = push_ok && !flush_i;
        if (flush_i) begin
            st_d = '0;
        end else begin
            if (push_ok) begin
                st_d.wr = ptr_next(st_q.wr);
            end
            if (pop_ok) begin
                st_d.rd = ptr_next(st_q.rd);
            end
            unique case ({push_ok, pop_ok})
                2'b10:   st_d.lvl = st_q.lvl + LVL_W'(1);
                2'b01:   st_d.lvl = st_q.lvl - LVL_W'(1);
                default: st_d.lvl = st_q.lvl;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    ift_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
        .clk_i   (clk_i),
        .we_i    (wr_en),
        .waddr_i (st_q.wr),
        .wdata_i (push_data_i),
        .raddr_i (st_q.rd),
        .rdata_o (pop_data_o)
    );

    ift_thresh #(.DEPTH(DEPTH)) u_thr (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .level_i  (st_q.lvl),
        .thr_i    (thr_i),
        .dir_rd_i (dir_rd_i),
        .flag_o   (thr_flag_o)
    );

    assign level_o   = st_q.lvl;
    assign empty_o   = (st_q.lvl == '0);
    assign full_o    = (st_q.lvl == CAP);
    assign irq_o     = thr_flag_o && irq_en_i;
    assign dma_req_o = thr_flag_o && dma_en_i;

    assert_level_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        level_o <= CAP);

    assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (full_o && push_i && !pop_i && !flush_i) |=> full_o);

    assert_no_underflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (empty_o && pop_i && !push_i && !flush_i) |=> empty_o);

    assert_push_counts_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!full_o && push_i && !pop_i && !flush_i) |=> level_o == $past(level_o) + LVL_W'(1));

    assert_both_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!full_o && !empty_o && push_i && pop_i && !flush_i) |=> $stable(level_o));

    assert_flush_empties_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> empty_o);

    assert_irq_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (thr_flag_o && irq_en_i));

    assert_dma_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dma_req_o |-> (thr_flag_o && dma_en_i));

endmodule

// File: tb/sim_ift_top.sv
module sim_ift_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       flush, dir_rd, irq_en, dma_en, push, pop;
    logic [5:0] thr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic [6:0] level;
    logic       empty, full, flag, irq, dma_req;

    int checks = 0;
    int fails  = 0;
    logic [7:0] mq[$];

    always #2 clk = ~clk;

    ift_top u0 (
        .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .dir_rd_i(dir_rd),
        .thr_i(thr), .irq_en_i(irq_en), .dma_en_i(dma_en), .push_i(push),
        .push_data_i(wdata), .pop_i(pop), .pop_data_o(rdata), .level_o(level),
        .empty_o(empty), .full_o(full), .thr_flag_o(flag), .irq_o(irq),
        .dma_req_o(dma_req)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_flag();
        int q;
        q = dir_rd ? mq.size() : 64 - mq.size();
        return (q >= int'(thr) + 1) ? 1 : 0;
    endfunction

    task automatic check_state(string req);
        chk(req, "level", int'(level), mq.size());
        chk(req, "empty", int'(empty), mq.size() == 0 ? 1 : 0);
        chk(req, "full", int'(full), mq.size() == 64 ? 1 : 0);
        if (mq.size() > 0) chk(req, "head", int'(rdata), int'(mq[0]));
        chk(req, "flag", int'(flag), exp_flag());
        chk(req, "irq", int'(irq), exp_flag() & int'(irq_en));
        chk(req, "dma", int'(dma_req), exp_flag() & int'(dma_en));
    endtask

    task automatic step(logic p, logic [7:0] d, logic q, logic f);
        bit push_ok, pop_ok;
        @(negedge clk);
        push = p; wdata = d; pop = q; flush = f;
        @(posedge clk);
        #1;
        push = 1'b0; pop = 1'b0; flush = 1'b0;
        if (f) begin
            mq.delete();
        end else begin
            push_ok = p && (mq.size() < 64);
            pop_ok  = q && (mq.size() > 0);
            if (pop_ok) void'(mq.pop_front());
            if (push_ok) mq.push_back(d);
        end
    endtask

    task automatic t_reset();
        dir_rd = 1'b1; thr = 6'd0;
        #1 check_state("R1");
        dir_rd = 1'b0; thr = 6'd63;
        #1 check_state("R1");
    endtask

    task automatic t_order();
        step(1'b0, 8'h0, 1'b0, 1'b1);
        for (int i = 0; i < 5; i++) begin
            step(1'b1, 8'(8'hA0 + i), 1'b0, 1'b0);
            check_state("R2");
        end
        for (int i = 0; i < 5; i++) begin
            chk("R2", "order", int'(rdata), 8'hA0 + i);
            step(1'b0, 8'h0, 1'b1, 1'b0);
            check_state("R2");
        end
    endtask

    task automatic t_overflow();
        step(1'b0, 8'h0, 1'b0, 1'b1);
        for (int i = 0; i < 64; i++) step(1'b1, 8'(i * 3), 1'b0, 1'b0);
        step(1'b1, 8'hEE, 1'b0, 1'b0);
        check_state("R3");
        step(1'b1, 8'hDD, 1'b0, 1'b0);
        chk("R3", "level_after_extra_push", int'(level), 64);
        for (int i = 0; i < 64; i++) begin
            chk("R3", "drain", int'(rdata), (i * 3) & 8'hFF);
            step(1'b0, 8'h0, 1'b1, 1'b0);
        end
        check_state("R3");
    endtask

    task automatic t_underflow();
        step(1'b0, 8'h0, 1'b1, 1'b0);
        check_state("R4");
        step(1'b0, 8'h0, 1'b1, 1'b0);
        chk("R4", "level", int'(level), 0);
    endtask

    task automatic t_simul();
        step(1'b0, 8'h0, 1'b0, 1'b1);
        step(1'b1, 8'h11, 1'b1, 1'b0);
        check_state("R5");
        chk("R5", "empty_push_only", int'(level), 1);
        step(1'b1, 8'h22, 1'b1, 1'b0);
        check_state("R5");
        chk("R5", "mid_head", int'(rdata), 8'h22);
        for (int i = 1; i < 64; i++) step(1'b1, 8'(i), 1'b0, 1'b0);
        step(1'b1, 8'h99, 1'b1, 1'b0);
        check_state("R5");
        chk("R5", "full_pop_only", int'(level), 63);
    endtask

    task automatic t_read_thr();
        int tv[3] = '{0, 5, 63};
        dir_rd = 1'b1;
        foreach (tv[k]) begin
            thr = 6'(tv[k]);
            step(1'b0, 8'h0, 1'b0, 1'b1);
            check_state("R6");
            for (int i = 0; i < 64; i++) begin
                step(1'b1, 8'(i), 1'b0, 1'b0);
                check_state("R6");
            end
        end
    endtask

    task automatic t_write_thr();
        int tv[3] = '{0, 17, 63};
        dir_rd = 1'b0;
        foreach (tv[k]) begin
            thr = 6'(tv[k]);
            step(1'b0, 8'h0, 1'b0, 1'b1);
            check_state("R7");
            for (int i = 0; i < 64; i++) begin
                step(1'b1, 8'(i), 1'b0, 1'b0);
                check_state("R7");
            end
        end
    endtask

    task automatic t_live();
        step(1'b0, 8'h0, 1'b0, 1'b1);
        for (int i = 0; i < 10; i++) step(1'b1, 8'(i), 1'b0, 1'b0);
        @(negedge clk);
        dir_rd = 1'b1; thr = 6'd9;
        #1 chk("R8", "flag_rd_thr9", int'(flag), 1);
        thr = 6'd10;
        #1 chk("R8", "flag_rd_thr10", int'(flag), 0);
        dir_rd = 1'b0;
        #1 chk("R8", "flag_wr_thr10", int'(flag), 1);
        thr = 6'd54;
        #1 chk("R8", "flag_wr_thr54", int'(flag), 0);
        thr = 6'd53;
        #1 chk("R8", "flag_wr_thr53", int'(flag), 1);
    endtask

    task automatic t_gates();
        dir_rd = 1'b0; thr = 6'd0;
        irq_en = 1'b0; dma_en = 1'b0;
        #1 check_state("R9");
        irq_en = 1'b1;
        #1 check_state("R9");
        chk("R9", "irq_on", int'(irq), 1);
        dma_en = 1'b1;
        #1 check_state("R10");
        chk("R10", "dma_on", int'(dma_req), 1);
        thr = 6'd63;
        #1 check_state("R10");
        chk("R10", "dma_flag_low", int'(dma_req), 0);
        chk("R9", "irq_flag_low", int'(irq), 0);
        irq_en = 1'b0; dma_en = 1'b0;
    endtask

    task automatic t_flush();
        for (int i = 0; i < 7; i++) step(1'b1, 8'(i), 1'b0, 1'b0);
        step(1'b1, 8'h55, 1'b1, 1'b1);
        check_state("R11");
        chk("R11", "level", int'(level), 0);
        step(1'b1, 8'h66, 1'b0, 1'b0);
        chk("R11", "head_after_refill", int'(rdata), 8'h66);
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog all actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; flush = 1'b0; dir_rd = 1'b1; irq_en = 1'b0;
        dma_en = 1'b0; push = 1'b0; pop = 1'b0; thr = 6'd0; wdata = 8'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_order();
        t_overflow();
        t_underflow();
        t_simul();
        t_read_thr();
        t_write_thr();
        t_live();
        t_gates();
        t_flush();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule